// File: doc/BRIEF.md
# Rectangular Byte Blitter

The blitter moves a rectangle of bytes inside a linear frame buffer. Software loads a few registers through a simple write port: the line pitches, the source, destination and tile base addresses, and a control word that holds the raster operation and the traversal direction. It then writes the size register. That write is itself the start command. The engine walks the rectangle one byte at a time. For each byte it reads a 32-bit word from the source or from an 8×8 byte tile, picks out the addressed byte lane and writes it into the destination through a byte-enabled word write. The busy flag stays high until the last byte has been written.

Overlapping copies are made safe by traversal direction. Software can choose right-to-left order, bottom-to-top order, or both. In that case it gives the addresses of the far edge and the engine steps downwards from them. A hold bit in a configuration register stops a running operation and keeps the engine idle for as long as it is set.

Top module: `blt_engine`

## Requirements
- R1: Register selects are 0 pitch, 1 source, 2 destination, 3 tile base, 4 control, 5 size, 6 configuration, and `reg_rdata` returns the selected register combinationally. Bit 31 of the control readback equals `busy`. The tile base keeps only address bits 21:3, and all other of its bits read back as 0. After reset every register reads 0 and `busy` is 0.
- R2: A size write (height in bits 31:16, width in bytes in bits 15:0) made while idle and not held starts an operation, and `busy` is 1 from the next cycle. If the width or the height is zero, nothing starts and no memory access happens.
- R3: With raster code 0xCC (control bits 7:0), destination byte (x, y) receives source byte (x, y). Each byte takes one read cycle followed by one write cycle, so `busy` is high for exactly 2·width·height cycles.
- R4: With raster code 0xF0, destination byte (x, y) receives the tile byte at tile base + 8·(y mod 8) + (x mod 8).
- R5: Any other raster code leaves memory untouched: no reads and no writes are made, and `busy` still lasts 2·width·height cycles.
- R6: Control bit 8 set makes byte x of a line sit at line base − x instead of line base + x, for both source and destination.
- R7: The pitch register holds the destination pitch in bits 31:16 and the source pitch in bits 15:0. Line y starts at base + y·pitch, or at base − y·pitch when control bit 9 is set.
- R8: While `busy` is 1, writes to every register except configuration are ignored. This includes the size register, and a running operation completes with its original settings.
- R9: Configuration bit 0 (hold) makes `busy` 0 one cycle after the hold is registered, ends the running operation without further accesses to later lines, and blocks size writes from starting while it is set.
- R10: The memory port carries word address = byte address ÷ 4 and little-endian lanes (lane k is byte address mod 4 = k). A write enables exactly one lane and carries the byte on all four lanes. Read data is returned the cycle after the read strobe. Read and write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| busy | output | 1 | Operation in progress |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data, byte on all lanes |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |

## Verification
A size write captured at clock edge k makes `busy` visible after that edge. The operation ends exactly 2·width·height edges later. The bench therefore samples on falling edges, counts the falling edges with `busy` high, and compares that count with the product. A hold registered at edge e must show `busy` low after edge e+1, and the bench samples exactly one falling edge after the write. Memory contents are compared over the whole modelled space only after `busy` has fallen, against a model computed from a snapshot taken before the start. Register readback is combinational, so it is sampled in the same low phase in which the select is driven.

// File: rtl/blt_pkg.sv
package blt_pkg;

    typedef enum logic [2:0] {
        RS_PITCH = 3'd0,
        RS_SRC   = 3'd1,
        RS_DST   = 3'd2,
        RS_TILE  = 3'd3,
        RS_CTRL  = 3'd4,
        RS_SIZE  = 3'd5,
        RS_CFG   = 3'd6
    } reg_sel_e;

    localparam logic [7:0] ROP_COPY = 8'hCC;
    localparam logic [7:0] ROP_TILE = 8'hF0;
    localparam int BIT_BUSY = 31;
    localparam int BIT_RTL  = 8;
    localparam int BIT_BTT  = 9;
    localparam int BIT_HOLD = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    typedef struct packed {
        logic [15:0] h;
        logic [15:0] w;
    } size_t;

    typedef struct packed {
        logic [15:0] dst;
        logic [15:0] src;
    } pitch_t;

    function automatic logic [3:0] lane_be(input logic [1:0] lane);
        return 4'b0001 << lane;
    endfunction

    function automatic logic [7:0] lane_byte(input logic [31:0] word, input logic [1:0] lane);
        return word[8*lane +: 8];
    endfunction

    function automatic logic rop_moves(input logic [7:0] rop);
        return (rop == ROP_COPY) || (rop == ROP_TILE);
    endfunction

endpackage

// File: rtl/blt_regs.sv
module blt_regs
    import blt_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output logic [31:0]       rdata,
    output pitch_t            pitch,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [ADDR_W-1:0] tile_base,
    output logic [7:0]        rop,
    output logic              dir_rtl,
    output logic              dir_btt,
    output size_t             size,
    output logic              hold,
    output logic              start
);
    localparam logic [ADDR_W-1:0] TILE_MASK = {{(ADDR_W-3){1'b1}}, 3'b000};
    localparam int PAD = 32 - ADDR_W;

    reg_sel_e    sel;
    logic        accept;
    logic [30:0] ctrl_q;

    assign sel    = reg_sel_e'(addr);
    assign accept = we && (!busy || sel == RS_CFG);
    assign start  = we && sel == RS_SIZE && !busy && !hold &&
                    wdata[31:16] != 16'd0 && wdata[15:0] != 16'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pitch     <= '0;
            src_base  <= '0;
            dst_base  <= '0;
            tile_base <= '0;
            ctrl_q    <= '0;
            size      <= '0;
            hold      <= 1'b0;
        end else if (accept) begin
            case (sel)
                RS_PITCH: pitch     <= pitch_t'(wdata);
                RS_SRC:   src_base  <= wdata[ADDR_W-1:0];
                RS_DST:   dst_base  <= wdata[ADDR_W-1:0];
                RS_TILE:  tile_base <= wdata[ADDR_W-1:0] & TILE_MASK;
                RS_CTRL:  ctrl_q    <= wdata[30:0];
                RS_SIZE:  size      <= size_t'(wdata);
                RS_CFG:   hold      <= wdata[BIT_HOLD];
                default:  ;
            endcase
        end
    end

    assign rop     = ctrl_q[7:0];
    assign dir_rtl = ctrl_q[BIT_RTL];
    assign dir_btt = ctrl_q[BIT_BTT];

    always_comb begin
        case (sel)
            RS_PITCH: rdata = pitch;
            RS_SRC:   rdata = {{PAD{1'b0}}, src_base};
            RS_DST:   rdata = {{PAD{1'b0}}, dst_base};
            RS_TILE:  rdata = {{PAD{1'b0}}, tile_base};
            RS_CTRL:  rdata = {busy, ctrl_q};
            RS_SIZE:  rdata = size;
            RS_CFG:   rdata = {31'd0, hold};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/blt_walker.sv
module blt_walker
    import blt_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int TILE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] tile_base,
    input  pitch_t            pitch,
    input  size_t             size,
    input  logic              dir_rtl,
    input  logic              dir_btt,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [ADDR_W-1:0] tile_addr,
    output logic              last
);
    localparam int TILE_IDX_W = 2 * TILE_LOG;

    logic [15:0]       x_q, y_q;
    logic [ADDR_W-1:0] sline_q, dline_q;
    logic [ADDR_W-1:0] x_off, sp, dp;
    logic              x_end, y_end;

    assign x_end = (x_q == size.w - 16'd1);
    assign y_end = (y_q == size.h - 16'd1);
    assign last  = x_end && y_end;
    assign x_off = ADDR_W'(x_q);
    assign sp    = ADDR_W'(pitch.src);
    assign dp    = ADDR_W'(pitch.dst);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            y_q     <= '0;
            sline_q <= '0;
            dline_q <= '0;
        end else if (load) begin
            x_q     <= '0;
            y_q     <= '0;
            sline_q <= src_base;
            dline_q <= dst_base;
        end else if (step) begin
            if (x_end) begin
                x_q     <= '0;
                y_q     <= y_q + 16'd1;
                sline_q <= dir_btt ? sline_q - sp : sline_q + sp;
                dline_q <= dir_btt ? dline_q - dp : dline_q + dp;
            end else begin
                x_q <= x_q + 16'd1;
            end
        end
    end

    assign src_addr  = dir_rtl ? sline_q - x_off : sline_q + x_off;
    assign dst_addr  = dir_rtl ? dline_q - x_off : dline_q + x_off;
    assign tile_addr = tile_base +
                       ADDR_W'(TILE_IDX_W'({y_q[TILE_LOG-1:0], x_q[TILE_LOG-1:0]}));

endmodule

// File: rtl/blt_engine.sv
module blt_engine
    import blt_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int TILE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    pitch_t            pitch;
    size_t             size;
    logic [ADDR_W-1:0] src_base, dst_base, tile_base;
    logic [ADDR_W-1:0] src_addr, dst_addr, tile_addr, rd_addr;
    logic [7:0]        rop_q;
    logic              dir_rtl, dir_btt, hold_q, start, last, moves;
    state_e            state_q;

    blt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .rdata    (reg_rdata),
        .pitch    (pitch),
        .src_base (src_base),
        .dst_base (dst_base),
        .tile_base(tile_base),
        .rop      (rop_q),
        .dir_rtl  (dir_rtl),
        .dir_btt  (dir_btt),
        .size     (size),
        .hold     (hold_q),
        .start    (start)
    );

    blt_walker #(.ADDR_W(ADDR_W), .TILE_LOG(TILE_LOG)) u_walker (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .step     (state_q == ST_WRITE && !hold_q),
        .src_base (src_base),
        .dst_base (dst_base),
        .tile_base(tile_base),
        .pitch    (pitch),
        .size     (size),
        .dir_rtl  (dir_rtl),
        .dir_btt  (dir_btt),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .tile_addr(tile_addr),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst || hold_q) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_READ;
                ST_READ:  state_q <= ST_WRITE;
                ST_WRITE: state_q <= last ? ST_IDLE : ST_READ;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign moves   = rop_moves(rop_q);
    assign rd_addr = (rop_q == ROP_TILE) ? tile_addr : src_addr;

    always_comb begin
        mem_re    = (state_q == ST_READ)  && moves;
        mem_we    = (state_q == ST_WRITE) && moves;
        mem_addr  = '0;
        mem_be    = 4'b0000;
        mem_wdata = {4{lane_byte(mem_rdata, rd_addr[1:0])}};
        if (mem_re) begin
            mem_addr = rd_addr[ADDR_W-1:2];
        end else if (mem_we) begin
            mem_addr = dst_addr[ADDR_W-1:2];
            mem_be   = lane_be(dst_addr[1:0]);
        end
    end

endmodule

// File: rtl/blt_engine_chk.sv
module blt_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_re,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        hold,
    input logic [7:0]  rop
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_re && !mem_we)); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd5 && !busy && !hold &&
         reg_wdata[31:16] != 16'd0 && reg_wdata[15:0] != 16'd0) |=> busy); // R2

    AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd5 && !busy &&
         (reg_wdata[31:16] == 16'd0 || reg_wdata[15:0] == 16'd0)) |=> !busy); // R2

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_re && !hold) |=> mem_we); // R3

    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (busy && rop != 8'hCC && rop != 8'hF0) |-> (!mem_re && !mem_we)); // R5

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rop)); // R8

    AST_HOLD_STOPS: assert property (@(posedge clk) disable iff (rst)
        hold |=> !busy); // R9

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) == 1)); // R10

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R10
endmodule

bind blt_engine blt_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_be   (mem_be),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .hold     (hold_q),
    .rop      (rop_q)
);

// File: tb/blt_engine_bench.sv
module blt_engine_bench;
    localparam int ADDR_W = 22;
    localparam int MEMB   = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        busy, mem_re, mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;

    logic [7:0] mem   [0:MEMB-1];
    logic [7:0] snap  [0:MEMB-1];
    logic [7:0] ref_m [0:MEMB-1];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    blt_engine #(.ADDR_W(ADDR_W)) u_blt_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= {mem[{mem_addr[9:0], 2'd3}], mem[{mem_addr[9:0], 2'd2}],
                          mem[{mem_addr[9:0], 2'd1}], mem[{mem_addr[9:0], 2'd0}]};
        if (mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[{mem_addr[9:0], 2'(k)}] <= mem_wdata[8*k +: 8];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < MEMB; i++) mem[i] = 8'((i * seed) + (i >> 4) + seed);
    endtask

    task automatic model(input int src, input int dst, input int tile,
                         input int sp, input int dp, input int w, input int h,
                         input logic [7:0] rop, input bit rl, input bit bt);
        for (int i = 0; i < MEMB; i++) begin snap[i] = mem[i]; ref_m[i] = mem[i]; end
        if (rop == 8'hCC || rop == 8'hF0)
            for (int y = 0; y < h; y++)
                for (int x = 0; x < w; x++) begin
                    int s, d, t;
                    s = src + (rl ? -x : x) + (bt ? -y * sp : y * sp);
                    d = dst + (rl ? -x : x) + (bt ? -y * dp : y * dp);
                    t = tile + 8 * (y % 8) + (x % 8);
                    ref_m[d & (MEMB-1)] = (rop == 8'hCC) ? snap[s & (MEMB-1)]
                                                          : snap[t & (MEMB-1)];
                end
    endtask

    task automatic launch(input int src, input int dst, input int tile,
                          input int sp, input int dp, input int w, input int h,
                          input logic [7:0] rop, input bit rl, input bit bt);
        model(src, dst, tile, sp, dp, w, h, rop, rl, bt);
        wr(3'd0, {16'(dp), 16'(sp)});
        wr(3'd1, 32'(src));
        wr(3'd2, 32'(dst));
        wr(3'd3, 32'(tile));
        wr(3'd4, {22'd0, bt, rl, rop});
        wr(3'd5, {16'(h), 16'(w)});
    endtask

    task automatic finish_op(input string req, input int exp_cycles);
        int cnt = 0;
        while (busy && cnt < 100000) begin
            cnt++;
            @(negedge clk);
        end
        if (exp_cycles >= 0) check(cnt == exp_cycles, req, "busy cycles", cnt, exp_cycles);
        else check(cnt < 100000, req, "completion", cnt, 0);
    endtask

    task automatic compare_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < MEMB; i++)
            if (mem[i] !== ref_m[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (bad != 0)
            check(0, req, $sformatf("byte @0x%0h", first), mem[first], ref_m[first]);
        else
            check(1, req, "memory", 0, 0);
    endtask

    task automatic run(input string req, input int src, input int dst, input int tile,
                       input int sp, input int dp, input int w, input int h,
                       input logic [7:0] rop, input bit rl, input bit bt);
        launch(src, dst, tile, sp, dp, w, h, rop, rl, bt);
        finish_op(req, 2 * w * h);
        compare_mem(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        fill(3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and readback
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        rd(3'd4, v); check(v == 32'd0, "R1", "ctrl after reset", v, 0);
        rd(3'd1, v); check(v == 32'd0, "R1", "src after reset", v, 0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); check(v == 32'h003F_FFF8, "R1", "tile base mask", v, 32'h003F_FFF8);

        // R3 / R10: copy sweep over sizes and byte alignments
        for (int w = 1; w <= 5; w++)
            for (int h = 1; h <= 3; h++) begin
                fill(w * 5 + h);
                run("R3", 32'h040 + w, 32'h400 + 3 * h + w, 0, 12, 20, w, h, 8'hCC, 0, 0);
            end

        // R4: tile fill, wrapping in both axes
        fill(7);
        run("R4", 0, 32'h900, 32'hF00, 0, 16, 10, 10, 8'hF0, 0, 0);
        fill(9);
        run("R4", 0, 32'h905, 32'hF40, 0, 7, 3, 9, 8'hF0, 0, 0);

        // R5: other raster codes leave memory untouched
        fill(11);
        run("R5", 32'h100, 32'h500, 0, 8, 8, 6, 4, 8'h5A, 0, 0);
        fill(13);
        run("R5", 32'h100, 32'h500, 0, 8, 8, 3, 2, 8'h00, 0, 0);

        // R6: overlapping copy to the right, traversed right to left
        fill(15);
        run("R6", 32'h200 + 15, 32'h203 + 15, 0, 32, 32, 16, 2, 8'hCC, 1, 0);

        // R7: overlapping copy one line down, traversed bottom to top
        fill(17);
        run("R7", 32'h300 + 48, 32'h310 + 48, 0, 16, 16, 8, 4, 8'hCC, 0, 1);
        // R7: different source and destination pitches
        fill(19);
        run("R7", 32'h100, 32'hC00, 0, 8, 20, 6, 5, 8'hCC, 0, 0);
        // R6 R7: both directions, shifted down and right
        fill(21);
        run("R6_R7", 32'hA00 + 4 * 32 + 11, 32'hA21 + 4 * 32 + 11, 0, 32, 32, 12, 5,
            8'hCC, 1, 1);

        // R2: zero width or zero height starts nothing
        fill(23);
        launch(32'h100, 32'h600, 0, 8, 8, 0, 5, 8'hCC, 0, 0);
        check(busy == 1'b0, "R2", "busy on zero width", busy, 0);
        compare_mem("R2");
        wr(3'd5, {16'd0, 16'd4});
        check(busy == 1'b0, "R2", "busy on zero height", busy, 0);
        compare_mem("R2");

        // R8 / R1: writes while busy are ignored, busy flag in control readback
        fill(25);
        launch(32'h100, 32'h800, 0, 16, 16, 16, 8, 8'hCC, 0, 0);
        rd(3'd4, v); check(v[31] == 1'b1, "R1", "ctrl busy bit", v[31], 1);
        wr(3'd1, 32'h345);
        wr(3'd4, 32'h0000_00F0);
        wr(3'd5, 32'h0001_0001);
        rd(3'd1, v); check(v == 32'h100, "R8", "src while busy", v, 32'h100);
        rd(3'd4, v); check(v[7:0] == 8'hCC, "R8", "rop while busy", v[7:0], 8'hCC);
        finish_op("R8", -1);
        compare_mem("R8");
        rd(3'd4, v); check(v[31] == 1'b0, "R1", "ctrl busy bit idle", v[31], 0);

        // R9: hold stops the operation and blocks new starts
        fill(27);
        launch(32'h100, 32'h600, 0, 16, 16, 16, 8, 8'hCC, 0, 0);
        repeat (10) @(negedge clk);
        wr(3'd6, 32'd1);
        @(negedge clk);
        check(busy == 1'b0, "R9", "busy after hold", busy, 0);
        wr(3'd5, {16'd2, 16'd2});
        check(busy == 1'b0, "R9", "start while held", busy, 0);
        begin
            int bad = 0;
            for (int i = 16; i < 128; i++)
                if (mem[32'h600 + i] !== snap[32'h600 + i]) bad++;
            check(bad == 0, "R9", "later lines untouched", bad, 0);
        end
        wr(3'd6, 32'd0);
        fill(29);
        run("R9", 32'h100, 32'h600, 0, 16, 16, 4, 2, 8'hCC, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule